// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block decides whether a conditional relative branch of an 8-bit processor is taken and produces the address execution continues from. A 3-bit condition code picks one of four status flags (negative, overflow, carry, zero) and states whether that flag must be clear or set. When the test passes, a signed 8-bit displacement is sign-extended and added to the incoming program counter, which already points past the branch instruction. When the test fails, the program counter passes through unchanged.

The decision, the next address and a page-crossing indication are combinational. A registered program counter copy loads the next address on an execute strobe, so the block can sit directly in a simple execute stage. The page-crossing output lets a sequencer add its own penalty cycle.

Top module: `brc_unit`

## Requirements
- R1: With condition code bits [2:1] = 00 the negative flag is tested; the branch is taken when that flag equals code bit 0 (code 000 takes on flag clear, 001 on flag set).
- R2: With bits [2:1] = 01 the overflow flag is tested the same way (010 clear, 011 set).
- R3: With bits [2:1] = 10 the carry flag is tested the same way (100 clear, 101 set).
- R4: With bits [2:1] = 11 the zero flag is tested the same way (110 clear, 111 set).
- R5: When taken, `next_pc` equals `pc_in` plus the displacement sign-extended to 16 bits, wrapping modulo 65536 (displacement 0x80 means -128, 0x7F means +127).
- R6: When not taken, `next_pc` equals `pc_in` whatever the displacement.
- R7: `page_cross` is 1 exactly when the branch is taken and bits [15:8] of `next_pc` differ from bits [15:8] of `pc_in`.
- R8: While `rst_n` is low, `pc_q` is held at the reset value 0x0000.
- R9: On a rising clock edge with `exec_en` high, `pc_q` takes the value `next_pc` had before the edge; with `exec_en` low, `pc_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_code | input | 3 | Branch condition: [2:1] flag select, [0] required flag value |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc_in | input | 16 | Program counter past the branch instruction |
| disp | input | 8 | Signed two's-complement displacement |
| exec_en | input | 1 | Execute strobe, loads `pc_q` |
| taken | output | 1 | Branch condition met |
| next_pc | output | 16 | Address to continue from |
| page_cross | output | 1 | Taken target lies in another 256-byte page |
| pc_q | output | 16 | Registered program counter |

## Verification
The decision, `next_pc` and `page_cross` are combinational, so they are due in the same cycle the inputs change. The bench drives inputs at the falling edge and samples them one nanosecond later, well before the next rising edge. `pc_q` is due one rising edge after a cycle with `exec_en` high. The bench therefore samples it one nanosecond after that edge, and after a further edge with the strobe low to confirm it holds.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [1:0] {
        SEL_NEG  = 2'b00,
        SEL_OVF  = 2'b01,
        SEL_CARRY = 2'b10,
        SEL_ZERO = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic carry;
        logic zero;
    } flags_t;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [2:0] cond_code,
    input  flags_t     flags,
    output logic       hit
);
    flag_sel_e sel;
    logic      tested;

    assign sel = flag_sel_e'(cond_code[2:1]);

    always_comb begin
        unique case (sel)
            SEL_NEG:   tested = flags.neg;
            SEL_OVF:   tested = flags.ovf;
            SEL_CARRY: tested = flags.carry;
            SEL_ZERO:  tested = flags.zero;
            default:   tested = 1'b0;
        endcase
    end

    assign hit = (tested == cond_code[0]);
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
    parameter int PC_W     = 16,
    parameter int DISP_W   = 8,
    parameter int PAGE_LSB = 8
) (
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [PC_W-1:0]   target,
    output logic              crossed
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] sum;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign sum      = pc_in + disp_ext;
    assign target   = take ? sum : pc_in;
    assign crossed  = take && (sum[PC_W-1:PAGE_LSB] != pc_in[PC_W-1:PAGE_LSB]);
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              DISP_W   = 8,
    parameter int              PAGE_LSB = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cond_code,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DISP_W-1:0] disp,
    input  logic              exec_en,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic              page_cross,
    output logic [PC_W-1:0]   pc_q
);
    flags_t flags;

    assign flags = '{neg: flag_n, ovf: flag_v, carry: flag_c, zero: flag_z};

    brc_cond_eval u_cond (
        .cond_code (cond_code),
        .flags     (flags),
        .hit       (taken)
    );

    brc_target_calc #(
        .PC_W     (PC_W),
        .DISP_W   (DISP_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_target (
        .pc_in   (pc_in),
        .disp    (disp),
        .take    (taken),
        .target  (next_pc),
        .crossed (page_cross)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_PC;
        else if (exec_en)
            pc_q <= next_pc;
    end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cond_code,
    input logic              flag_n,
    input logic              flag_v,
    input logic              flag_c,
    input logic              flag_z,
    input logic [PC_W-1:0]   pc_in,
    input logic [DISP_W-1:0] disp,
    input logic              exec_en,
    input logic              taken,
    input logic [PC_W-1:0]   next_pc,
    input logic              page_cross,
    input logic [PC_W-1:0]   pc_q
);
    logic [PC_W-1:0] step;
    assign step = next_pc - pc_in;

    a_r1_neg_test: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[2:1] == 2'b00) |-> (taken == (flag_n == cond_code[0])));
    a_r4_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[2:1] == 2'b11) |-> (taken == (flag_z == cond_code[0])));
    a_r5_taken_offset: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (step == {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp}));
    a_r6_not_taken_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (next_pc == pc_in));
    a_r7_cross_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross |-> taken);
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> (pc_q == $past(next_pc)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en && rst_n) |=> $stable(pc_q));
endmodule

bind brc_unit brc_unit_chk #(.PC_W(PC_W), .DISP_W(DISP_W)) u_chk (.*);

// File: tb/tb_brc_unit.sv
`timescale 1ns/1ps
module tb_brc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cond_code = '0;
    logic        flag_n = 0, flag_v = 0, flag_c = 0, flag_z = 0;
    logic [15:0] pc_in = '0;
    logic [7:0]  disp = '0;
    logic        exec_en = 1'b0;
    logic        taken, page_cross;
    logic [15:0] next_pc, pc_q;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    brc_unit dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sum16(input logic [15:0] p, input logic [7:0] d);
        int s;
        s = int'(p) + int'($signed(d));
        return 16'(s & 32'hFFFF);
    endfunction

    initial begin
        #150000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pcs [4];
        logic [15:0] exp_pc;
        logic        exp_take;
        logic        f;
        pcs[0] = 16'h0000; pcs[1] = 16'h12F0; pcs[2] = 16'hFF80; pcs[3] = 16'h8005;

        @(negedge clk); @(negedge clk);
        #1 check("R8 reset pc_q", pc_q, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        // R1..R4 exhaustive over codes and flags
        pc_in = 16'h4000; disp = 8'h10;
        for (int cc = 0; cc < 8; cc++) begin
            for (int fl = 0; fl < 16; fl++) begin
                @(negedge clk);
                cond_code = 3'(cc);
                {flag_n, flag_v, flag_c, flag_z} = 4'(fl);
                #1;
                case (cc >> 1)
                    0: f = flag_n;
                    1: f = flag_v;
                    2: f = flag_c;
                    default: f = flag_z;
                endcase
                exp_take = (f == cc[0]);
                case (cc >> 1)
                    0: check("R1 neg test", taken, exp_take);
                    1: check("R2 ovf test", taken, exp_take);
                    2: check("R3 carry test", taken, exp_take);
                    default: check("R4 zero test", taken, exp_take);
                endcase
            end
        end

        // R5/R6/R7 displacement sweep
        cond_code = 3'b111;
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 256; d++) begin
                for (int t = 0; t < 2; t++) begin
                    @(negedge clk);
                    pc_in = pcs[p]; disp = 8'(d); flag_z = t[0];
                    #1;
                    exp_pc = t[0] ? sum16(pcs[p], 8'(d)) : pcs[p];
                    if (t[0]) check("R5 taken target", next_pc, exp_pc);
                    else      check("R6 not-taken pass", next_pc, exp_pc);
                    check("R7 page cross", page_cross,
                          t[0] && (exp_pc[15:8] != pcs[p][15:8]));
                end
            end
        end

        // R9 load and hold
        @(negedge clk);
        pc_in = 16'hFFF0; disp = 8'h20; cond_code = 3'b100; flag_c = 1'b0; exec_en = 1'b1;
        @(posedge clk); #1;
        check("R9 load taken wrap", pc_q, 16'h0010);
        @(negedge clk);
        exec_en = 1'b0; pc_in = 16'h1234;
        @(posedge clk); #1;
        check("R9 hold", pc_q, 16'h0010);
        @(negedge clk);
        flag_c = 1'b1; exec_en = 1'b1;
        @(posedge clk); #1;
        check("R9 load not taken", pc_q, 16'h1234);
        @(negedge clk);
        exec_en = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8 reset again", pc_q, 16'h0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule